// File: doc/BRIEF.md
# Banked Effective Address Generator

This block forms the 24-bit data address for the non-indirect operand addressing modes of an 8/16-bit processor that has a 24-bit address space. The instruction sequencer supplies several inputs and pulses a start strobe: the operand bytes, the mode code, the direct-page base, the stack pointer, the data bank, both index registers, and the emulation and index-width flags. One clock later the block returns the address together with a one-cycle valid flag.

The wrap rule depends on both the mode and the processor state. Direct-page and stack-relative results stay in bank 0. In emulation mode, a direct-page offset wraps inside a 256-byte window. Absolute indexing wraps inside the data bank in emulation mode and carries into the bank byte in native mode. Long modes always carry across banks.

Top module: `bank_ea_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `ea` becomes 0 and `ea_valid` becomes 0.
- R2: If `start` is high with a legal mode at a clock edge, `ea_valid` is high for exactly the next cycle and `ea` carries the result. Otherwise, `ea_valid` is low and `ea` holds its previous value.
- R3: The mode codes are: 0 direct, 1 direct+X, 2 direct+Y, 3 absolute, 4 absolute+X, 5 absolute+Y, 6 long, 7 long+X, 8 stack-relative. Codes 9 to 15 are illegal: they raise no `ea_valid` and leave `ea` unchanged.
- R4: The effective index is the low 8 bits of the selected register, zero-extended, when `emu`=1 or `idx_narrow`=1. Otherwise it is all 16 bits.
- R5: Direct mode gives `{8'h00, (dp_base + operand[7:0]) mod 2^16}`.
- R6: Direct indexed in emulation: the offset is `(operand[7:0] + index) mod 256`, and the result is `{8'h00, (dp_base + offset) mod 2^16}`.
- R7: Direct indexed in native mode gives `{8'h00, (dp_base + operand[7:0] + index) mod 2^16}`. This is never an 8-bit wrap.
- R8: Absolute mode gives `{data_bank, operand[15:0]}`.
- R9: Absolute indexed in emulation gives `{data_bank, (operand[15:0] + index) mod 2^16}`.
- R10: Absolute indexed in native mode gives `({data_bank, operand[15:0]} + index) mod 2^24`.
- R11: The long modes give `(operand + index) mod 2^24` in both emulation and native mode. The index is zero for mode 6.
- R12: Stack-relative gives `{8'h00, (sp_base + operand[7:0]) mod 2^16}`. It uses no index.
- R13: Operand bits above those a mode uses have no effect on `ea`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe |
| mode | input | 4 | Addressing-mode code |
| operand | input | 24 | Operand bytes, low-aligned |
| dp_base | input | 16 | Direct-page base register |
| sp_base | input | 16 | Stack pointer |
| data_bank | input | 8 | Data bank register |
| idx_x | input | 16 | X index register |
| idx_y | input | 16 | Y index register |
| emu | input | 1 | Emulation-mode flag |
| idx_narrow | input | 1 | 1 = 8-bit index registers in native mode |
| ea | output | 24 | Effective address |
| ea_valid | output | 1 | Result valid, one cycle |

## Verification
The assertions check four things on every cycle:
- `ea_valid` follows only a legal start, and `ea` holds between results.
- Illegal codes never raise `ea_valid`.
- Direct-page and stack results stay in bank 0, and emulation direct-page results stay within 256 bytes above the base.
- Emulation absolute results keep the data bank byte.

Only the bench scenarios can show the exact sums. These include the carries that reach the bank byte in native mode, the 24-bit rollover, the narrowing of the index, and the fact that unused operand bits are ignored.

// File: rtl/bea_pkg.sv
package bea_pkg;
    localparam int ADDR_W = 24;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int BANK_W = ADDR_W - WORD_W;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        AM_DIR    = 4'd0,
        AM_DIR_X  = 4'd1,
        AM_DIR_Y  = 4'd2,
        AM_ABS    = 4'd3,
        AM_ABS_X  = 4'd4,
        AM_ABS_Y  = 4'd5,
        AM_LONG   = 4'd6,
        AM_LONG_X = 4'd7,
        AM_STK    = 4'd8
    } am_code_e;

    typedef enum logic [1:0] {
        K_DP   = 2'd0,
        K_STK  = 2'd1,
        K_ABS  = 2'd2,
        K_LONG = 2'd3
    } ea_kind_e;

    typedef enum logic [1:0] {
        IX_NONE = 2'd0,
        IX_X    = 2'd1,
        IX_Y    = 2'd2
    } idx_src_e;

    typedef struct packed {
        logic     legal;
        ea_kind_e kind;
        idx_src_e src;
    } am_dec_t;

    function automatic am_dec_t decode_mode(input logic [MODE_W-1:0] code);
        am_dec_t d;
        d.legal = 1'b1;
        d.kind  = K_DP;
        d.src   = IX_NONE;
        case (code)
            AM_DIR:    begin d.kind = K_DP;   d.src = IX_NONE; end
            AM_DIR_X:  begin d.kind = K_DP;   d.src = IX_X;    end
            AM_DIR_Y:  begin d.kind = K_DP;   d.src = IX_Y;    end
            AM_ABS:    begin d.kind = K_ABS;  d.src = IX_NONE; end
            AM_ABS_X:  begin d.kind = K_ABS;  d.src = IX_X;    end
            AM_ABS_Y:  begin d.kind = K_ABS;  d.src = IX_Y;    end
            AM_LONG:   begin d.kind = K_LONG; d.src = IX_NONE; end
            AM_LONG_X: begin d.kind = K_LONG; d.src = IX_X;    end
            AM_STK:    begin d.kind = K_STK;  d.src = IX_NONE; end
            default:   d.legal = 1'b0;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/bea_index_sel.sv
module bea_index_sel
    import bea_pkg::*;
(
    input  idx_src_e             src,
    input  logic [WORD_W-1:0]    idx_x,
    input  logic [WORD_W-1:0]    idx_y,
    input  logic                 emu,
    input  logic                 idx_narrow,
    output logic [WORD_W-1:0]    idx
);
    logic [WORD_W-1:0] raw;
    logic              narrow;

    assign narrow = emu | idx_narrow;

    always_comb begin
        case (src)
            IX_X:    raw = idx_x;
            IX_Y:    raw = idx_y;
            default: raw = '0;
        endcase
    end

    assign idx = narrow ? {{(WORD_W-BYTE_W){1'b0}}, raw[BYTE_W-1:0]} : raw;
endmodule

// File: rtl/bea_bank0_calc.sv
module bea_bank0_calc
    import bea_pkg::*;
(
    input  logic [WORD_W-1:0] base,
    input  logic [BYTE_W-1:0] off8,
    input  logic [WORD_W-1:0] idx,
    input  logic              emu,
    output logic [WORD_W-1:0] addr
);
    logic [BYTE_W-1:0] short_off;
    logic [WORD_W-1:0] offset;

    assign short_off = off8 + idx[BYTE_W-1:0];

    always_comb begin
        if (emu)
            offset = {{(WORD_W-BYTE_W){1'b0}}, short_off};
        else
            offset = {{(WORD_W-BYTE_W){1'b0}}, off8} + idx;
    end

    assign addr = base + offset;
endmodule

// File: rtl/bea_far_calc.sv
module bea_far_calc
    import bea_pkg::*;
(
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] op,
    input  logic [WORD_W-1:0] idx,
    input  logic              long_mode,
    input  logic              emu,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] base;
    logic [WORD_W-1:0] in_bank;

    assign base    = long_mode ? op : {bank, op[WORD_W-1:0]};
    assign in_bank = op[WORD_W-1:0] + idx;

    always_comb begin
        if (!long_mode && emu)
            addr = {bank, in_bank};
        else
            addr = base + {{(ADDR_W-WORD_W){1'b0}}, idx};
    end
endmodule

// File: rtl/bank_ea_gen.sv
module bank_ea_gen
    import bea_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic [23:0]       operand,
    input  logic [15:0]       dp_base,
    input  logic [15:0]       sp_base,
    input  logic [7:0]        data_bank,
    input  logic [15:0]       idx_x,
    input  logic [15:0]       idx_y,
    input  logic              emu,
    input  logic              idx_narrow,
    output logic [23:0]       ea,
    output logic              ea_valid
);
    am_dec_t           dec;
    logic [WORD_W-1:0] idx;
    logic [WORD_W-1:0] near_base;
    logic [WORD_W-1:0] near_addr;
    logic [ADDR_W-1:0] far_addr;
    logic [ADDR_W-1:0] next_ea;
    logic              near_sel;
    logic              take;

    assign dec      = decode_mode(mode);
    assign near_sel = (dec.kind == K_DP) || (dec.kind == K_STK);
    assign near_base = (dec.kind == K_STK) ? sp_base : dp_base;
    assign take     = start && dec.legal;

    bea_index_sel u_idx (
        .src        (dec.src),
        .idx_x      (idx_x),
        .idx_y      (idx_y),
        .emu        (emu),
        .idx_narrow (idx_narrow),
        .idx        (idx)
    );

    bea_bank0_calc u_near (
        .base (near_base),
        .off8 (operand[BYTE_W-1:0]),
        .idx  (idx),
        .emu  (emu),
        .addr (near_addr)
    );

    bea_far_calc u_far (
        .bank      (data_bank),
        .op        (operand),
        .idx       (idx),
        .long_mode (dec.kind == K_LONG),
        .emu       (emu),
        .addr      (far_addr)
    );

    assign next_ea = near_sel ? {{BANK_W{1'b0}}, near_addr} : far_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ea       <= '0;
            ea_valid <= 1'b0;
        end else begin
            ea_valid <= take;
            if (take)
                ea <= next_ea;
        end
    end

    // R2
    valid_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
        ea_valid |-> $past(start));

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ea_valid |-> $stable(ea));

    // R3
    illegal_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !dec.legal) |=> !ea_valid);

    // R5
    bank0_only_chk: assert property (@(posedge clk) disable iff (rst)
        (start && dec.legal && near_sel) |=> (ea[ADDR_W-1:WORD_W] == '0));

    // R6
    emu_window_chk: assert property (@(posedge clk) disable iff (rst)
        (start && dec.legal && emu && dec.kind == K_DP)
            |=> ((ea[WORD_W-1:0] - $past(dp_base)) < 16'd256));

    // R9
    emu_abs_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (start && dec.legal && emu && dec.kind == K_ABS)
            |=> (ea[ADDR_W-1:WORD_W] == $past(data_bank)));
endmodule

// File: tb/test_bank_ea_gen.sv
module test_bank_ea_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [3:0]  mode;
    logic [23:0] operand;
    logic [15:0] dp_base, sp_base, idx_x, idx_y;
    logic [7:0]  data_bank;
    logic        emu, idx_narrow;
    logic [23:0] ea;
    logic        ea_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bank_ea_gen i_bank_ea_gen (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .operand(operand),
        .dp_base(dp_base), .sp_base(sp_base), .data_bank(data_bank),
        .idx_x(idx_x), .idx_y(idx_y), .emu(emu), .idx_narrow(idx_narrow),
        .ea(ea), .ea_valid(ea_valid)
    );

    task automatic check_val(string req, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
        end
    endtask

    task automatic issue(logic [3:0] m, logic [23:0] op, logic [15:0] d,
                         logic [15:0] s, logic [7:0] b, logic [15:0] x,
                         logic [15:0] y, logic e, logic n);
        @(negedge clk);
        mode = m; operand = op; dp_base = d; sp_base = s; data_bank = b;
        idx_x = x; idx_y = y; emu = e; idx_narrow = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic expect_ea(string req, logic [23:0] exp);
        check_val({req, " valid"}, {23'd0, ea_valid}, 24'd1);
        check_val(req, ea, exp);
    endtask

    task automatic t_reset;
        check_val("R1 ea", ea, 24'h0);
        check_val("R1 valid", {23'd0, ea_valid}, 24'd0);
    endtask

    task automatic t_direct;
        issue(4'd0, 24'hABCD34, 16'h1200, 16'h0, 8'h55, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
        expect_ea("R5 R13 direct", 24'h001234);
        @(negedge clk);
        check_val("R2 valid one cycle", {23'd0, ea_valid}, 24'd0);
        check_val("R2 hold", ea, 24'h001234);
        issue(4'd0, 24'h000090, 16'hFF80, 16'h0, 8'h55, 16'h0, 16'h0, 1'b1, 1'b0);
        expect_ea("R5 bank0 wrap", 24'h000010);
    endtask

    task automatic t_direct_emu;
        issue(4'd1, 24'h000020, 16'h0300, 16'h0, 8'h00, 16'h12F0, 16'h0, 1'b1, 1'b0);
        expect_ea("R6 R4 emu dirX 8-bit wrap", 24'h000310);
        issue(4'd2, 24'h000001, 16'hFF01, 16'h0, 8'h00, 16'h0, 16'h00FF, 1'b1, 1'b0);
        expect_ea("R6 emu dirY offset wrap", 24'h00FF01);
        issue(4'd2, 24'h0000FF, 16'hFF01, 16'h0, 8'h00, 16'h0, 16'h0000, 1'b1, 1'b0);
        expect_ea("R6 emu base wrap to 0", 24'h000000);
    endtask

    task automatic t_direct_native;
        issue(4'd1, 24'h000020, 16'h0300, 16'h0, 8'h00, 16'h12F0, 16'h0, 1'b0, 1'b0);
        expect_ea("R7 native dirX wide", 24'h001610);
        issue(4'd2, 24'h000020, 16'h0300, 16'h0, 8'h00, 16'h0, 16'h12F0, 1'b0, 1'b1);
        expect_ea("R7 R4 native dirY narrow", 24'h000410);
        issue(4'd1, 24'h000001, 16'hFFF0, 16'h0, 8'h00, 16'h0020, 16'h0, 1'b0, 1'b0);
        expect_ea("R7 native bank0 wrap", 24'h000011);
    endtask

    task automatic t_absolute;
        issue(4'd3, 24'h123456, 16'h0, 16'h0, 8'h7E, 16'h1111, 16'h2222, 1'b0, 1'b0);
        expect_ea("R8 R13 abs", 24'h7E3456);
        issue(4'd4, 24'h00FFF0, 16'h0, 16'h0, 8'h02, 16'h0020, 16'h0, 1'b1, 1'b0);
        expect_ea("R9 emu absX bank wrap", 24'h020010);
        issue(4'd5, 24'h00FFF0, 16'h0, 16'h0, 8'h02, 16'h0, 16'h0120, 1'b0, 1'b0);
        expect_ea("R10 native absY carry", 24'h030110);
        issue(4'd4, 24'h00FFFF, 16'h0, 16'h0, 8'hFF, 16'h0001, 16'h0, 1'b0, 1'b0);
        expect_ea("R10 native 24-bit wrap", 24'h000000);
    endtask

    task automatic t_long;
        issue(4'd6, 24'h02F000, 16'h0, 16'h0, 8'h33, 16'h5555, 16'h0, 1'b0, 1'b0);
        expect_ea("R11 long", 24'h02F000);
        issue(4'd7, 24'h02F000, 16'h0, 16'h0, 8'h33, 16'hFFFF, 16'h0, 1'b0, 1'b0);
        expect_ea("R11 native longX", 24'h03EFFF);
        issue(4'd7, 24'h01FFFF, 16'h0, 16'h0, 8'h33, 16'h1234, 16'h0, 1'b1, 1'b0);
        expect_ea("R11 R4 emu longX crosses bank", 24'h020033);
        issue(4'd7, 24'hFFFFF0, 16'h0, 16'h0, 8'h33, 16'h0020, 16'h0, 1'b0, 1'b0);
        expect_ea("R11 longX 24-bit wrap", 24'h000010);
    endtask

    task automatic t_stack;
        issue(4'd8, 24'hFFFF13, 16'h4000, 16'h01F0, 8'h44, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
        expect_ea("R12 R13 stack", 24'h000203);
        issue(4'd8, 24'h000002, 16'h4000, 16'hFFFF, 8'h44, 16'h0, 16'h0, 1'b1, 1'b0);
        expect_ea("R12 stack bank0 wrap", 24'h000001);
    endtask

    task automatic t_illegal;
        for (int c = 9; c < 16; c++) begin
            issue(c[3:0], 24'h777777, 16'h1, 16'h1, 8'h1, 16'h1, 16'h1, 1'b0, 1'b0);
            check_val("R3 illegal no valid", {23'd0, ea_valid}, 24'd0);
            check_val("R3 illegal ea held", ea, 24'h000001);
        end
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; mode = '0; operand = '0; dp_base = '0;
        sp_base = '0; data_bank = '0; idx_x = '0; idx_y = '0; emu = 1'b0;
        idx_narrow = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_direct();
        t_direct_emu();
        t_direct_native();
        t_absolute();
        t_long();
        t_stack();
        t_illegal();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule